// File: doc/BRIEF.md
# Multicore private peripheral address decoder

This block sits on a simple register bus and decodes every access that falls inside an 8 KB private window shared by a cluster of one to four CPU cores. A small snoop-control bank lives inside the block: a read/write control word, a read-only configuration word built from the core count, a CPU status word that reads as zero, and a write-only invalidate-all word that turns a write into a one-cycle pulse.

The rest of the window belongs to per-core resources that sit outside the block. Each core has one interrupt-controller CPU interface and two timers. Every such resource can be reached in two ways. An alias window always means "the core making this access", taken from the requester ID input. A set of explicit windows, one per core at a 256-byte stride, names a core directly. The decoder raises one select strobe and gives the target core, the timer number and the sub-offset. It then returns, one cycle later, the data that the selected resource supplied. An access to a core that is not present raises no strobe, reads as zero and has no effect when written. This also covers a requester whose ID is not below the core count.

Top module: `ppw_decoder`

## Requirements
- R1: The control word answers at offsets 0x000 to 0x003, since address bits 1:0 are ignored in the snoop-control bank. A write stores `bus_wdata` and a later read returns the stored value. Reset clears it to zero.
- R2: The configuration word answers at 0x004. It reads as ((2^NUM_CORES − 1) << 4) | (NUM_CORES − 1). Writes to it change nothing.
- R3: The status word at 0x008 reads as zero. The invalidate word at 0x00C reads as zero. A write to 0x00C drives `inval_pulse` high for exactly the one cycle after the write, with `inval_data` equal to the written value.
- R4: `rvalid` is high in exactly the cycle after a cycle with `bus_rd` high, and `rdata` then carries the read result. While `rvalid` is low, `rdata` is zero.
- R5: A read or write in 0x100 to 0x1FF raises `icpu_sel` in the same cycle, with `tgt_core` equal to `req_core` and `sub_off` equal to address bits 7:0.
- R6: A read or write in 0x200 to 0x5FF raises `icpu_sel`, with `tgt_core` = (offset − 0x200) >> 8 and `sub_off` equal to address bits 7:0.
- R7: A read or write in 0x600 to 0x6FF targets timers of `req_core`, and one in 0x700 to 0xAFF targets timers of core (offset − 0x700) >> 8. Either raises `tmr_sel`. `tmr_idx` is 2·core + address bit 5, and `sub_off` is address bits 3:0 zero-extended.
- R8: When the resolved core index is not below NUM_CORES, no select or `per_we` is raised and a read returns zero. This applies to explicit windows and to the alias windows.
- R9: Offsets 0x010 to 0x0FF and 0xB00 to 0x1FFF raise no select and read as zero. Writes to them leave the control word unchanged.
- R10: A read that selects a CPU interface or a timer returns, one cycle later, the value on `icpu_rdata` or `tmr_rdata` during the strobe cycle. `per_we` is high with a select exactly when `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte offset inside the window |
| bus_wr | input | 1 | Write enable for this cycle |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe for this cycle |
| req_core | input | 2 | ID of the core making the access |
| icpu_sel | output | 1 | Select strobe toward the interrupt CPU interfaces |
| tmr_sel | output | 1 | Select strobe toward the timers |
| per_we | output | 1 | Write qualifier for the selected per-core resource |
| tgt_core | output | 2 | Resolved target core |
| tmr_idx | output | 3 | Timer number, 2·core + pair member |
| sub_off | output | 8 | Offset passed to the selected resource |
| icpu_rdata | input | DW | Read data from the selected CPU interface |
| tmr_rdata | input | DW | Read data from the selected timer |
| rdata | output | DW | Registered read result |
| rvalid | output | 1 | Read result valid |
| inval_pulse | output | 1 | One-cycle invalidate-all pulse |
| inval_data | output | DW | Value written with the invalidate request |

## Verification
Select strobes, `per_we`, `tgt_core`, `tmr_idx` and `sub_off` are combinational. The bench checks them one time unit after it drives the inputs at the falling edge, before the next rising edge. Read results are due one rising edge after the strobe. The driver pushes the expected word into a queue, and a monitor at every falling edge compares `rvalid` against the strobe seen at the previous rising edge and pops the queue when valid. The invalidate pulse is checked at the first falling edge after the write's rising edge and again one cycle later, when it must be gone.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
  localparam int MAX_CORES = 4;
  localparam int CORE_W    = $clog2(MAX_CORES);
  localparam int WIN_BYTES = 8192;
  localparam int WIN_AW    = $clog2(WIN_BYTES);
  localparam int SUB_W     = 8;
  localparam int DATA_W    = 32;

  // Region boundaries inside the window (end offsets are exclusive)
  localparam logic [WIN_AW-1:0] SCU_END   = WIN_AW'(16'h0010);
  localparam logic [WIN_AW-1:0] GAP_END   = WIN_AW'(16'h0100);
  localparam logic [WIN_AW-1:0] IALIAS_END = WIN_AW'(16'h0200);
  localparam logic [WIN_AW-1:0] IBANK_END = WIN_AW'(16'h0600);
  localparam logic [WIN_AW-1:0] TALIAS_END = WIN_AW'(16'h0700);
  localparam logic [WIN_AW-1:0] TBANK_END = WIN_AW'(16'h0B00);

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_SCU  = 2'd1,
    RG_ICPU = 2'd2,
    RG_TMR  = 2'd3
  } region_t;

  // Configuration word: per-core presence mask at bit 4 upward, count-1 below
  function automatic logic [DATA_W-1:0] cfg_word(input int n);
    logic [DATA_W-1:0] mask;
    mask = (DATA_W'(1) << n) - DATA_W'(1);
    return (mask << 4) | DATA_W'(n - 1);
  endfunction
endpackage

// File: rtl/ppw_region_dec.sv
module ppw_region_dec
  import ppw_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [WIN_AW-1:0] addr,
  input  logic [CORE_W-1:0] req_core,
  output region_t           region,
  output logic [CORE_W-1:0] core,
  output logic [CORE_W:0]   tmr_idx,
  output logic [SUB_W-1:0]  sub_off,
  output logic [1:0]        scu_word
);
  localparam logic [CORE_W:0] NC = (CORE_W+1)'(NUM_CORES);

  region_t           raw;
  logic [CORE_W-1:0] raw_core;
  logic              present;

  always_comb begin
    raw      = RG_NONE;
    raw_core = req_core;
    if (addr < SCU_END) begin
      raw = RG_SCU;
    end else if (addr < GAP_END) begin
      raw = RG_NONE;
    end else if (addr < IALIAS_END) begin
      raw = RG_ICPU;
    end else if (addr < IBANK_END) begin
      raw = RG_ICPU;
      // offsets 0x2xx..0x5xx: bits 9:8 = 2,3,0,1 -> cores 0..3
      raw_core = addr[9:8] ^ 2'b10;
    end else if (addr < TALIAS_END) begin
      raw = RG_TMR;
    end else if (addr < TBANK_END) begin
      raw = RG_TMR;
      // offsets 0x7xx..0xAxx: bits 9:8 = 3,0,1,2 -> cores 0..3
      raw_core = addr[9:8] + 2'd1;
    end
  end

  assign present = ({1'b0, raw_core} < NC);

  always_comb begin
    region = raw;
    if ((raw == RG_ICPU || raw == RG_TMR) && !present) region = RG_NONE;
  end

  always_comb begin
    core     = '0;
    tmr_idx  = '0;
    sub_off  = '0;
    scu_word = '0;
    unique case (region)
      RG_SCU:  scu_word = addr[3:2];
      RG_ICPU: begin
        core    = raw_core;
        sub_off = addr[7:0];
      end
      RG_TMR: begin
        core    = raw_core;
        tmr_idx = {raw_core, addr[5]};
        sub_off = {4'h0, addr[3:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ppw_scu_bank.sv
module ppw_scu_bank
  import ppw_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DW        = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [1:0]    word,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic          inval_pulse,
  output logic [DW-1:0] inval_data
);
  localparam logic [DW-1:0] CFG_VAL = DW'(cfg_word(NUM_CORES));

  logic [DW-1:0] ctrl_q;
  logic          wr_ctrl;
  logic          wr_inval;

  assign wr_ctrl  = hit && wr && (word == 2'd0);
  assign wr_inval = hit && wr && (word == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inval_pulse <= 1'b0;
      inval_data  <= '0;
    end else begin
      inval_pulse <= wr_inval;
      if (wr_inval) inval_data <= wdata;
    end
  end

  always_comb begin
    unique case (word)
      2'd0:    rd_val = ctrl_q;
      2'd1:    rd_val = CFG_VAL;
      default: rd_val = '0;
    endcase
  end

  // R1: control word only moves on a write aimed at it
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ctrl_q));

  // R3: every invalidate pulse is caused by a write to the invalidate word
  p_inval_cause_r3: assert property (@(posedge clk) disable iff (rst)
    inval_pulse |-> $past(hit && wr && (word == 2'd3)));
endmodule

// File: rtl/ppw_rd_ret.sv
module ppw_rd_ret
  import ppw_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  region_t       region,
  input  logic [DW-1:0] scu_val,
  input  logic [DW-1:0] icpu_val,
  input  logic [DW-1:0] tmr_val,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] pick;

  always_comb begin
    unique case (region)
      RG_SCU:  pick = scu_val;
      RG_ICPU: pick = icpu_val;
      RG_TMR:  pick = tmr_val;
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? pick : '0;
    end
  end
endmodule

// File: rtl/ppw_decoder.sv
module ppw_decoder
  import ppw_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DW        = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  input  logic [CORE_W-1:0] req_core,
  output logic              icpu_sel,
  output logic              tmr_sel,
  output logic              per_we,
  output logic [CORE_W-1:0] tgt_core,
  output logic [CORE_W:0]   tmr_idx,
  output logic [SUB_W-1:0]  sub_off,
  input  logic [DW-1:0]     icpu_rdata,
  input  logic [DW-1:0]     tmr_rdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              inval_pulse,
  output logic [DW-1:0]     inval_data
);
  localparam logic [CORE_W:0] NC = (CORE_W+1)'(NUM_CORES);

  region_t       region;
  logic [1:0]    scu_word;
  logic [DW-1:0] scu_val;
  logic          acc;
  logic          per_hit;

  ppw_region_dec #(.NUM_CORES(NUM_CORES)) u_dec (
    .addr     (bus_addr),
    .req_core (req_core),
    .region   (region),
    .core     (tgt_core),
    .tmr_idx  (tmr_idx),
    .sub_off  (sub_off),
    .scu_word (scu_word)
  );

  assign acc      = bus_rd || bus_wr;
  assign per_hit  = (region == RG_ICPU) || (region == RG_TMR);
  assign icpu_sel = acc && (region == RG_ICPU);
  assign tmr_sel  = acc && (region == RG_TMR);
  assign per_we   = bus_wr && per_hit;

  ppw_scu_bank #(.NUM_CORES(NUM_CORES), .DW(DW)) u_scu (
    .clk         (clk),
    .rst         (rst),
    .hit         (region == RG_SCU),
    .word        (scu_word),
    .wr          (bus_wr),
    .wdata       (bus_wdata),
    .rd_val      (scu_val),
    .inval_pulse (inval_pulse),
    .inval_data  (inval_data)
  );

  ppw_rd_ret #(.DW(DW)) u_ret (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .region   (region),
    .scu_val  (scu_val),
    .icpu_val (icpu_rdata),
    .tmr_val  (tmr_rdata),
    .rdata    (rdata),
    .rvalid   (rvalid)
  );

  // R4: valid follows the read strobe by one cycle
  p_rvalid_lag_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rvalid == $past(bus_rd)));

  // R4: no stale data while not valid
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));

  // R8: a strobe never points at an absent core
  p_sel_present_r8: assert property (@(posedge clk) disable iff (rst)
    (icpu_sel || tmr_sel) |-> ({1'b0, tgt_core} < NC));

  // R7: timer number is the pair of the target core, member from bit 5
  p_tmr_pair_r7: assert property (@(posedge clk) disable iff (rst)
    tmr_sel |-> (tmr_idx[CORE_W:1] == tgt_core && tmr_idx[0] == bus_addr[5]));

  // R5: alias window of the CPU interface targets the requester
  p_alias_core_r5: assert property (@(posedge clk) disable iff (rst)
    (icpu_sel && bus_addr >= GAP_END && bus_addr < IALIAS_END) |-> (tgt_core == req_core));
endmodule

// File: tb/ppw_decoder_bench.sv
module ppw_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [1:0]  req_core = '0;
  logic        icpu_sel, tmr_sel, per_we, rvalid, inval_pulse;
  logic [1:0]  tgt_core;
  logic [2:0]  tmr_idx;
  logic [7:0]  sub_off;
  logic [31:0] icpu_rdata, tmr_rdata, rdata, inval_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;

  typedef struct {
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Peripheral stand-ins: data encodes which resource was selected
  assign icpu_rdata = 32'hA000_0000 | {22'b0, tgt_core, sub_off};
  assign tmr_rdata  = 32'hB000_0000 | {21'b0, tmr_idx, sub_off};

  ppw_decoder #(.NUM_CORES(NCORE), .DW(32)) u_ppw_decoder (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .req_core(req_core),
    .icpu_sel(icpu_sel), .tmr_sel(tmr_sel), .per_we(per_we),
    .tgt_core(tgt_core), .tmr_idx(tmr_idx), .sub_off(sub_off),
    .icpu_rdata(icpu_rdata), .tmr_rdata(tmr_rdata), .rdata(rdata),
    .rvalid(rvalid), .inval_pulse(inval_pulse), .inval_data(inval_data)
  );

  function automatic void chk(input bit ok, input string tag,
                              input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  always @(posedge clk) rd_seen <= rst ? 1'b0 : bus_rd;

  // Monitor: timing of valid, and scoreboard compare
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rvalid == rd_seen, "R4 rvalid timing", {31'b0, rvalid}, {31'b0, rd_seen});
      if (rvalid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R4 unexpected read result", rdata, 32'h0);
        end else begin
          exp_t it;
          it = sb.pop_front();
          chk(rdata == it.d, it.tag, rdata, it.d);
        end
      end else begin
        chk(rdata == 32'h0, "R4 idle rdata", rdata, 32'h0);
      end
    end
  end

  task automatic put(input logic [12:0] a, input logic [1:0] c,
                     input logic w, input logic r, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; req_core = c; bus_wr = w; bus_rd = r; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd_exp(input logic [12:0] a, input logic [1:0] c,
                        input logic [31:0] e, input string tag);
    exp_t it;
    put(a, c, 1'b0, 1'b1, 32'h0);
    it.d = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr_sel(input logic [12:0] a, input logic [1:0] c,
                        input logic ei, input logic et, input logic [1:0] ec,
                        input logic [2:0] ex, input logic [7:0] es, input string tag);
    put(a, c, 1'b1, 1'b0, 32'hDEAD_0000 | {19'b0, a});
    #1;
    chk(icpu_sel == ei, {tag, " icpu_sel"}, {31'b0, icpu_sel}, {31'b0, ei});
    chk(tmr_sel == et, {tag, " tmr_sel"}, {31'b0, tmr_sel}, {31'b0, et});
    chk(per_we == (ei | et), {tag, " per_we R10"}, {31'b0, per_we}, {31'b0, ei | et});
    if (ei | et) begin
      chk(tgt_core == ec, {tag, " tgt_core"}, {30'b0, tgt_core}, {30'b0, ec});
      chk(sub_off == es, {tag, " sub_off"}, {24'b0, sub_off}, {24'b0, es});
    end
    if (et) chk(tmr_idx == ex, {tag, " tmr_idx"}, {29'b0, tmr_idx}, {29'b0, ex});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(rvalid == 1'b0, "R4 reset rvalid", {31'b0, rvalid}, 32'h0);
    chk(inval_pulse == 1'b0, "R3 reset pulse", {31'b0, inval_pulse}, 32'h0);
    chk(icpu_sel == 1'b0 && tmr_sel == 1'b0, "R8 reset sel", {30'b0, icpu_sel, tmr_sel}, 32'h0);

    // R1: reset value, store and read back, low address bits ignored
    rd_exp(13'h000, 2'd0, 32'h0, "R1 ctrl after reset");
    put(13'h000, 2'd1, 1'b1, 1'b0, 32'h5A5A_1234);
    rd_exp(13'h000, 2'd0, 32'h5A5A_1234, "R1 ctrl readback");
    rd_exp(13'h002, 2'd2, 32'h5A5A_1234, "R1 ctrl low bits ignored");

    // R2: configuration word, write ignored
    rd_exp(13'h004, 2'd0, ((32'd1 << NCORE) - 1) << 4 | (NCORE - 1), "R2 cfg value");
    put(13'h004, 2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    rd_exp(13'h004, 2'd0, 32'h0000_0072, "R2 cfg after write");
    rd_exp(13'h000, 2'd0, 32'h5A5A_1234, "R2 cfg write left ctrl");

    // R3: status and invalidate words read as zero
    rd_exp(13'h008, 2'd0, 32'h0, "R3 status zero");
    rd_exp(13'h00C, 2'd0, 32'h0, "R3 invalidate reads zero");
    put(13'h00C, 2'd0, 1'b1, 1'b0, 32'h0000_00F5);
    idle();
    chk(inval_pulse == 1'b1, "R3 pulse high", {31'b0, inval_pulse}, 32'h1);
    chk(inval_data == 32'hF5, "R3 pulse data", inval_data, 32'hF5);
    idle();
    chk(inval_pulse == 1'b0, "R3 pulse one cycle", {31'b0, inval_pulse}, 32'h0);

    // R5: CPU interface alias window
    wr_sel(13'h1A4, 2'd1, 1, 0, 2'd1, 3'd0, 8'hA4, "R5 alias");
    wr_sel(13'h100, 2'd2, 1, 0, 2'd2, 3'd0, 8'h00, "R5 alias base");
    // R6: explicit CPU interface windows
    wr_sel(13'h2C8, 2'd2, 1, 0, 2'd0, 3'd0, 8'hC8, "R6 core0");
    wr_sel(13'h4F0, 2'd0, 1, 0, 2'd2, 3'd0, 8'hF0, "R6 core2");
    // R7: timer windows
    wr_sel(13'h624, 2'd2, 0, 1, 2'd2, 3'd5, 8'h04, "R7 alias");
    wr_sel(13'h808, 2'd0, 0, 1, 2'd1, 3'd2, 8'h08, "R7 core1");
    wr_sel(13'h92C, 2'd0, 0, 1, 2'd2, 3'd5, 8'h0C, "R7 core2 second");
    // R8: absent core 3, explicit and via alias
    wr_sel(13'h500, 2'd0, 0, 0, 2'd0, 3'd0, 8'h00, "R8 icpu core3");
    wr_sel(13'hA10, 2'd0, 0, 0, 2'd0, 3'd0, 8'h00, "R8 timer core3");
    wr_sel(13'h100, 2'd3, 0, 0, 2'd0, 3'd0, 8'h00, "R8 icpu alias req3");
    wr_sel(13'h640, 2'd3, 0, 0, 2'd0, 3'd0, 8'h00, "R8 timer alias req3");
    // R9: undecoded offsets
    wr_sel(13'h010, 2'd0, 0, 0, 2'd0, 3'd0, 8'h00, "R9 gap");
    wr_sel(13'h0FC, 2'd0, 0, 0, 2'd0, 3'd0, 8'h00, "R9 gap end");
    wr_sel(13'hB00, 2'd0, 0, 0, 2'd0, 3'd0, 8'h00, "R9 above timers");
    wr_sel(13'h1FFC, 2'd0, 0, 0, 2'd0, 3'd0, 8'h00, "R9 window top");
    idle();

    // R10 reads back-to-back through both paths
    rd_exp(13'h1A4, 2'd1, 32'hA000_01A4, "R10 icpu alias read");
    rd_exp(13'h310, 2'd0, 32'hA000_0110, "R10 icpu core1 read");
    rd_exp(13'h734, 2'd2, 32'hB000_0104, "R10 timer core0 read");
    rd_exp(13'h630, 2'd2, 32'hB000_0500, "R10 timer alias read");
    rd_exp(13'h5FC, 2'd0, 32'h0, "R8 absent icpu read");
    rd_exp(13'hA00, 2'd0, 32'h0, "R8 absent timer read");
    rd_exp(13'h180, 2'd3, 32'h0, "R8 absent requester read");
    rd_exp(13'h040, 2'd0, 32'h0, "R9 gap read");
    rd_exp(13'hC00, 2'd0, 32'h0, "R9 high read");
    put(13'h040, 2'd0, 1'b1, 1'b0, 32'h1111_1111);
    put(13'h1000, 2'd0, 1'b1, 1'b0, 32'h2222_2222);
    rd_exp(13'h000, 2'd0, 32'h5A5A_1234, "R9 ctrl unchanged");
    idle();
    repeat (3) idle();
    chk(sb.size() == 0, "R4 all reads answered", sb.size(), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule